// File: doc/BRIEF.md
# HDLC Transmit FIFO Controller

A byte-wide transmit buffer placed between a processor register port and an HDLC serializer. Software writes frame bytes one at a time and then issues a command. A frame-continue command hands every byte written so far to the serializer. A message-end command does the same and also flags the last byte as the end of the frame. A transmit-reset command empties the buffer. Only bytes handed over by a command are offered to the serializer. Several complete frames may be stored at once, as long as they fit.

The capacity depends on the channel kind. It is 64 bytes for a signalling channel and 128 bytes for a bearer channel. Software selects a block size, small or large: 16/32 bytes for signalling, 32/64 bytes for bearer. A "pool ready" interrupt tells software that at least one block of space is free. The block guards against three faults. Running dry in the middle of a frame is an underrun. Losing the channel after the first block of a frame has gone out is a repeat failure. Writing more than a block between two commands is an overflow. If the channel drops before the first block has gone out, the frame is replayed without software help.

Top module: `hdlc_tx_fifo`

## Requirements
- R1: After reset, `irq`, `irq_xpr`, `irq_xdu`, `irq_xmr`, `xdov` and `tx_valid` are all low.
- R2: Written bytes reach the serializer in write order, but only after a frame-continue or message-end command. Each byte is taken on a cycle with `tx_valid` and `tx_req` both high. `tx_eof` is high with the last byte that was written before a message-end command.
- R3: While the active block size is N, the (N+1)th write since the last command sets `xdov`. `xdov` then stays high until a transmit-reset command.
- R4: A new `bsize_sel` value (0 = small, 1 = large) becomes the active block size only on a frame-continue, message-end or transmit-reset command.
- R5: `irq_xpr` is set when the buffer is armed and its free space is at least the active block size. The buffer is armed by reset, by any command and by an error. Setting `irq_xpr` disarms it. A status read (`ista_rd`) clears `irq_xpr`.
- R6: Bytes of the frame being sent are counted as occupied until a full block of that frame has been taken. Only then does their space count as free.
- R7: If `tx_req` is high during a frame and no handed-over byte is left, `irq_xdu` is set and the buffer is emptied.
- R8: If `tx_chan_ok` falls during a frame before a full block has been taken, the frame is offered again from its first byte, and no interrupt is raised.
- R9: If `tx_chan_ok` falls during a frame after a full block has been taken, `irq_xmr` is set and the buffer is emptied.
- R10: While `irq_xdu` or `irq_xmr` is pending, writes, frame-continue commands and message-end commands are ignored. A status read clears both bits and releases the lock in the same cycle.
- R11: A transmit-reset command empties the buffer, so `tx_valid` is low on the next cycle.
- R12: Two or more complete frames may sit in the buffer together. Each one ends with its own `tx_eof`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Processor byte write strobe |
| wr_data | input | 8 | Byte to write |
| cmd_cont | input | 1 | Frame-continue command pulse |
| cmd_end | input | 1 | Message-end command pulse |
| cmd_reset | input | 1 | Transmit-reset command pulse |
| bsize_sel | input | 1 | Requested block size, 0 small, 1 large |
| ista_rd | input | 1 | Interrupt status read pulse |
| irq | output | 1 | Any interrupt pending |
| irq_xpr | output | 1 | Pool ready pending |
| irq_xdu | output | 1 | Underrun pending |
| irq_xmr | output | 1 | Repeat failure pending |
| xdov | output | 1 | Write overflow status |
| tx_req | input | 1 | Serializer takes a byte |
| tx_chan_ok | input | 1 | Channel available |
| tx_valid | output | 1 | Handed-over byte offered |
| tx_data | output | 8 | Offered byte |
| tx_eof | output | 1 | Offered byte ends its frame |

## Verification
The bench checks the free-space threshold while a frame is partly sent. A design that freed the space of the first block too early would raise the ready interrupt while fewer than a block of bytes had been taken. Channel loss is tested on both sides of the first block boundary. A wrong boundary would either replay a frame whose start is already lost or fail a frame that could have been repeated. The bench also writes while a fault is pending, and writes 17 bytes after asking for a larger block size without a command. A design that dropped the lock would expose those bytes. A design that applied the new size at once would not set overflow.

// File: rtl/hdlc_txf_pkg.sv
package hdlc_txf_pkg;

    typedef struct packed {
        logic xpr;
        logic xdu;
        logic xmr;
        logic lock;
        logic armed;
    } irq_st_t;

    function automatic int depth_for(input bit bearer);
        return bearer ? 128 : 64;
    endfunction

    function automatic int blk_small_for(input bit bearer);
        return bearer ? 32 : 16;
    endfunction

endpackage

// File: rtl/hdlc_txf_ram.sv
module hdlc_txf_ram #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          mark_en,
    input  logic [AW-1:0] mark_addr,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          reof
);
    logic [DW-1:0] dat_mem [DEPTH];
    logic          eof_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            dat_mem[waddr] <= wdata;
            eof_mem[waddr] <= mark_en && (mark_addr == waddr);
        end
        if (mark_en && !(we && (mark_addr == waddr))) begin
            eof_mem[mark_addr] <= 1'b1;
        end
    end

    assign rdata = dat_mem[raddr];
    assign reof  = eof_mem[raddr];
endmodule

// File: rtl/hdlc_txf_ctrl.sv
module hdlc_txf_ctrl #(
    parameter int DEPTH  = 64,
    parameter int BLK_S  = 16,
    parameter int DW     = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1,
    localparam int BLK_L = 2 * BLK_S
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          cmd_cont,
    input  logic          cmd_end,
    input  logic          cmd_reset,
    input  logic          bsize_sel,
    input  logic          lock,
    input  logic          tx_req,
    input  logic          tx_chan_ok,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          tx_eof,
    output logic          xdov,
    output logic          xpr_cond,
    output logic          xdu_evt,
    output logic          xmr_evt,
    output logic          arm_evt
);
    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [PW-1:0] cm;
        logic [PW-1:0] fs;
        logic [PW-1:0] sent;
        logic [PW-1:0] wcnt;
        logic          in_frame;
        logic          bsel;
        logic          xdov;
    } ctrl_st_t;

    ctrl_st_t q, d;

    logic [PW-1:0] blk, base, used, free, wr_next, last_ptr;
    logic          hold, avail, take, wr_ok, eff_cmd, chan_drop, replay, wipe;
    logic          ram_we, ram_mark, ram_eof;
    logic [AW-1:0] ram_maddr;

    assign blk       = q.bsel ? PW'(BLK_L) : PW'(BLK_S);
    assign hold      = q.in_frame && (q.sent < blk);
    assign base      = hold ? q.fs : q.rd;
    assign used      = q.wr - base;
    assign free      = PW'(DEPTH) - used;
    assign avail     = (q.cm != q.rd);
    assign tx_valid  = avail && tx_chan_ok;
    assign take      = tx_valid && tx_req;
    assign wr_ok     = wr_en && !lock && (free != '0);
    assign eff_cmd   = (cmd_cont || cmd_end) && !lock;
    assign wr_next   = q.wr + PW'(wr_ok);
    assign last_ptr  = wr_next - 1'b1;
    assign xdu_evt   = q.in_frame && tx_req && tx_chan_ok && !avail;
    assign chan_drop = q.in_frame && !tx_chan_ok;
    assign xmr_evt   = chan_drop && !hold;
    assign replay    = chan_drop && hold;
    assign wipe      = xdu_evt || xmr_evt || cmd_reset;
    assign xpr_cond  = (free >= blk);
    assign arm_evt   = eff_cmd || wipe;
    assign xdov      = q.xdov;
    assign tx_eof    = tx_valid && ram_eof;

    always_comb begin
        d         = q;
        ram_we    = 1'b0;
        ram_mark  = 1'b0;
        ram_maddr = last_ptr[AW-1:0];

        if (wr_ok) begin
            d.wr   = wr_next;
            ram_we = 1'b1;
            if (q.wcnt >= blk) d.xdov = 1'b1;
            if (q.wcnt != '1) d.wcnt = q.wcnt + 1'b1;
        end

        if (eff_cmd) begin
            d.cm   = wr_next;
            d.wcnt = '0;
            d.bsel = bsize_sel;
            if (cmd_end && (wr_next != q.cm)) ram_mark = 1'b1;
        end

        if (take) begin
            d.rd = q.rd + 1'b1;
            if (ram_eof) begin
                d.in_frame = 1'b0;
                d.sent     = '0;
                d.fs       = q.rd + 1'b1;
            end else begin
                d.in_frame = 1'b1;
                if (q.sent < blk) d.sent = q.sent + 1'b1;
            end
        end

        if (replay) begin
            d.rd       = q.fs;
            d.sent     = '0;
            d.in_frame = 1'b0;
        end

        if (wipe) begin
            d.wr       = '0;
            d.rd       = '0;
            d.cm       = '0;
            d.fs       = '0;
            d.sent     = '0;
            d.wcnt     = '0;
            d.in_frame = 1'b0;
            ram_we     = 1'b0;
            ram_mark   = 1'b0;
            if (cmd_reset) begin
                d.xdov = 1'b0;
                d.bsel = bsize_sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    hdlc_txf_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
        .clk      (clk),
        .we       (ram_we),
        .waddr    (q.wr[AW-1:0]),
        .wdata    (wr_data),
        .mark_en  (ram_mark),
        .mark_addr(ram_maddr),
        .raddr    (q.rd[AW-1:0]),
        .rdata    (tx_data),
        .reof     (ram_eof)
    );
endmodule

// File: rtl/hdlc_txf_irq.sv
module hdlc_txf_irq
    import hdlc_txf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xpr_cond,
    input  logic xdu_evt,
    input  logic xmr_evt,
    input  logic arm_evt,
    input  logic ista_rd,
    output logic irq_xpr,
    output logic irq_xdu,
    output logic irq_xmr,
    output logic lock,
    output logic irq
);
    irq_st_t q, d;
    logic    set_xpr;

    assign set_xpr = q.armed && xpr_cond && !q.lock;

    always_comb begin
        d       = q;
        d.xpr   = set_xpr || (q.xpr && !ista_rd);
        d.xdu   = xdu_evt || (q.xdu && !ista_rd);
        d.xmr   = xmr_evt || (q.xmr && !ista_rd);
        d.lock  = xdu_evt || xmr_evt || (q.lock && !ista_rd);
        if (arm_evt)      d.armed = 1'b1;
        else if (set_xpr) d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{xpr: 1'b0, xdu: 1'b0, xmr: 1'b0, lock: 1'b0, armed: 1'b1};
        else        q <= d;
    end

    assign irq_xpr = q.xpr;
    assign irq_xdu = q.xdu;
    assign irq_xmr = q.xmr;
    assign lock    = q.lock;
    assign irq     = q.xpr || q.xdu || q.xmr;
endmodule

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
    import hdlc_txf_pkg::*;
#(
    parameter bit BEARER = 1'b0,
    parameter int DW     = 8,
    localparam int DEPTH = depth_for(BEARER),
    localparam int BLK_S = blk_small_for(BEARER)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          cmd_cont,
    input  logic          cmd_end,
    input  logic          cmd_reset,
    input  logic          bsize_sel,
    input  logic          ista_rd,
    output logic          irq,
    output logic          irq_xpr,
    output logic          irq_xdu,
    output logic          irq_xmr,
    output logic          xdov,
    input  logic          tx_req,
    input  logic          tx_chan_ok,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          tx_eof
);
    logic lock, xpr_cond, xdu_evt, xmr_evt, arm_evt;

    hdlc_txf_ctrl #(.DEPTH(DEPTH), .BLK_S(BLK_S), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cmd_cont  (cmd_cont),
        .cmd_end   (cmd_end),
        .cmd_reset (cmd_reset),
        .bsize_sel (bsize_sel),
        .lock      (lock),
        .tx_req    (tx_req),
        .tx_chan_ok(tx_chan_ok),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_eof    (tx_eof),
        .xdov      (xdov),
        .xpr_cond  (xpr_cond),
        .xdu_evt   (xdu_evt),
        .xmr_evt   (xmr_evt),
        .arm_evt   (arm_evt)
    );

    hdlc_txf_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .xpr_cond(xpr_cond),
        .xdu_evt (xdu_evt),
        .xmr_evt (xmr_evt),
        .arm_evt (arm_evt),
        .ista_rd (ista_rd),
        .irq_xpr (irq_xpr),
        .irq_xdu (irq_xdu),
        .irq_xmr (irq_xmr),
        .lock    (lock),
        .irq     (irq)
    );
endmodule

// File: rtl/hdlc_tx_fifo_chk.sv
module hdlc_tx_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic cmd_cont,
    input logic cmd_end,
    input logic cmd_reset,
    input logic ista_rd,
    input logic irq_xdu,
    input logic irq_xmr,
    input logic xdov,
    input logic tx_valid
);
    // R3: overflow status only leaves on a transmit-reset
    p_xdov_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xdov && !cmd_reset |=> xdov);

    // R7: underrun leaves the buffer empty
    p_xdu_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_xdu) |-> !tx_valid);

    // R9: repeat failure leaves the buffer empty
    p_xmr_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_xmr) |-> !tx_valid);

    // R10: nothing becomes visible while a fault is pending
    p_lock_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_xdu || irq_xmr) && !ista_rd && !tx_valid |=> !tx_valid);

    // R11: transmit-reset empties the buffer
    p_reset_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> !tx_valid);

    // R1: no interrupt during reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> !irq_xdu && !irq_xmr && !xdov);

    logic unused_ok;
    assign unused_ok = wr_en ^ cmd_cont ^ cmd_end;
endmodule

bind hdlc_tx_fifo hdlc_tx_fifo_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .cmd_cont (cmd_cont),
    .cmd_end  (cmd_end),
    .cmd_reset(cmd_reset),
    .ista_rd  (ista_rd),
    .irq_xdu  (irq_xdu),
    .irq_xmr  (irq_xmr),
    .xdov     (xdov),
    .tx_valid (tx_valid)
);

// File: tb/hdlc_tx_fifo_tb.sv
module hdlc_tx_fifo_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, cmd_cont = 1'b0, cmd_end = 1'b0, cmd_reset = 1'b0;
    logic       bsize_sel = 1'b0, ista_rd = 1'b0, tx_req = 1'b0, tx_chan_ok = 1'b1;
    logic [7:0] wr_data = '0;
    logic       irq, irq_xpr, irq_xdu, irq_xmr, xdov, tx_valid, tx_eof;
    logic [7:0] tx_data;

    int         n_chk = 0, n_fail = 0;
    string      cur_tag = "R2";
    logic [8:0] exp_q[$];
    logic [7:0] staged[$];

    always #2 clk = ~clk;

    hdlc_tx_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cmd_cont(cmd_cont), .cmd_end(cmd_end), .cmd_reset(cmd_reset),
        .bsize_sel(bsize_sel), .ista_rd(ista_rd), .irq(irq),
        .irq_xpr(irq_xpr), .irq_xdu(irq_xdu), .irq_xmr(irq_xmr), .xdov(xdov),
        .tx_req(tx_req), .tx_chan_ok(tx_chan_ok), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_eof(tx_eof)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic put(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        step;
        wr_en = 1'b0;
        staged.push_back(b);
    endtask

    task automatic commit(input bit last);
        int n;
        if (last) cmd_end = 1'b1; else cmd_cont = 1'b1;
        step;
        cmd_end = 1'b0; cmd_cont = 1'b0;
        n = staged.size();
        for (int i = 0; i < n; i++) exp_q.push_back({last && (i == n - 1), staged[i]});
        staged.delete();
    endtask

    task automatic pulse_reset_cmd;
        cmd_reset = 1'b1; step; cmd_reset = 1'b0;
        staged.delete();
    endtask

    task automatic status_read;
        ista_rd = 1'b1; step; ista_rd = 1'b0;
    endtask

    task automatic take_n(input int n);
        tx_req = 1'b1;
        repeat (n) step;
        tx_req = 1'b0;
    endtask

    task automatic drain(input int n, input string tag);
        take_n(n);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    // monitor: pops expected bytes as the serializer takes them
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_req) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, cur_tag, {tx_eof, tx_data}, 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk({tx_eof, tx_data} == e, cur_tag, {tx_eof, tx_data}, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) step;
        rst_n = 1'b1;
        // R1: reset state
        chk(!irq && !irq_xpr && !irq_xdu && !irq_xmr, "R1", irq, 0);
        chk(!xdov && !tx_valid, "R1", {xdov, tx_valid}, 0);
        step;
        chk(irq_xpr == 1'b1, "R5", irq_xpr, 1);
        status_read;
        step;
        chk(irq_xpr == 1'b0, "R5", irq_xpr, 0);

        // R2: single frame, hidden until committed
        cur_tag = "R2";
        for (int i = 0; i < 10; i++) put(8'h10 + 8'(i));
        chk(tx_valid == 1'b0, "R2", tx_valid, 0);
        commit(1'b1);
        drain(12, "R2");

        // R12: two frames stored together
        cur_tag = "R12";
        for (int i = 0; i < 5; i++) put(8'h30 + 8'(i));
        commit(1'b1);
        for (int i = 0; i < 7; i++) put(8'h50 + 8'(i));
        commit(1'b1);
        drain(14, "R12");

        // R5 / R6: threshold with the first block held
        cur_tag = "R6";
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 16; i++) put(8'(k * 16 + i));
            commit(1'b0);
        end
        put(8'hA0); put(8'hA1);
        commit(1'b0);
        status_read;
        step;
        chk(irq_xpr == 1'b0, "R5", irq_xpr, 0);
        take_n(10);
        step;
        chk(irq_xpr == 1'b0, "R6", irq_xpr, 0);
        take_n(10);
        step; step;
        chk(irq_xpr == 1'b1, "R6", irq_xpr, 1);
        put(8'hA2);
        commit(1'b1);
        drain(35, "R6");

        // R4 / R3: block size latch and overflow
        bsize_sel = 1'b1;
        for (int i = 0; i < 17; i++) put(8'(i));
        step;
        chk(xdov == 1'b1, "R4", xdov, 1);
        cmd_cont = 1'b1; step; cmd_cont = 1'b0;
        staged.delete();
        step;
        chk(xdov == 1'b1, "R3", xdov, 1);
        pulse_reset_cmd;
        chk(xdov == 1'b0, "R3", xdov, 0);
        chk(tx_valid == 1'b0, "R11", tx_valid, 0);
        for (int i = 0; i < 20; i++) put(8'(i));
        chk(xdov == 1'b0, "R4", xdov, 0);
        cmd_cont = 1'b1; step; cmd_cont = 1'b0;
        staged.delete();
        chk(tx_valid == 1'b1, "R11", tx_valid, 1);
        pulse_reset_cmd;
        chk(tx_valid == 1'b0, "R11", tx_valid, 0);
        bsize_sel = 1'b0;
        pulse_reset_cmd;

        // R7 / R10: underrun, lock, release
        cur_tag = "R7";
        status_read;
        for (int i = 0; i < 4; i++) put(8'hC0 + 8'(i));
        commit(1'b0);
        take_n(6);
        chk(irq_xdu == 1'b1 && irq == 1'b1, "R7", irq_xdu, 1);
        chk(tx_valid == 1'b0, "R7", tx_valid, 0);
        for (int i = 0; i < 3; i++) put(8'hD0 + 8'(i));
        cmd_end = 1'b1; step; cmd_end = 1'b0;
        staged.delete();
        chk(tx_valid == 1'b0, "R10", tx_valid, 0);
        chk(irq_xdu == 1'b1, "R10", irq_xdu, 1);
        status_read;
        chk(irq_xdu == 1'b0, "R10", irq_xdu, 0);
        cur_tag = "R10";
        for (int i = 0; i < 3; i++) put(8'hE0 + 8'(i));
        commit(1'b1);
        drain(5, "R10");

        // R8: replay before the first block is out
        cur_tag = "R8";
        for (int i = 0; i < 16; i++) put(8'h40 + 8'(i));
        commit(1'b0);
        for (int i = 16; i < 20; i++) put(8'h40 + 8'(i));
        commit(1'b1);
        take_n(5);
        exp_q.delete();
        for (int i = 0; i < 20; i++) exp_q.push_back({i == 19, 8'h40 + 8'(i)});
        tx_chan_ok = 1'b0; step; tx_chan_ok = 1'b1;
        chk(irq_xmr == 1'b0, "R8", irq_xmr, 0);
        drain(24, "R8");
        chk(irq_xmr == 1'b0 && irq_xdu == 1'b0, "R8", irq_xmr, 0);

        // R9: repeat failure after the first block
        cur_tag = "R9";
        for (int i = 0; i < 16; i++) put(8'h60 + 8'(i));
        commit(1'b0);
        for (int i = 16; i < 20; i++) put(8'h60 + 8'(i));
        commit(1'b1);
        take_n(18);
        tx_chan_ok = 1'b0; step; tx_chan_ok = 1'b1;
        exp_q.delete();
        step;
        chk(irq_xmr == 1'b1, "R9", irq_xmr, 1);
        chk(tx_valid == 1'b0, "R9", tx_valid, 0);
        put(8'hFF);
        cmd_end = 1'b1; step; cmd_end = 1'b0;
        staged.delete();
        chk(tx_valid == 1'b0, "R10", tx_valid, 0);
        status_read;
        chk(irq_xmr == 1'b0, "R10", irq_xmr, 0);

        step;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule